// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder

This block adds two unsigned operands of `WIDTH` bits and a single incoming carry. It returns a `WIDTH`-bit sum and the carry that leaves the most significant bit. The block is purely combinational, with no clock and no registers.

The bit positions are split into slices of three. Inside a slice, each bit forms a generate term (the AND of its two operand bits) and a propagate term (the OR of its two operand bits). Every carry inside the slice is then formed directly as a flat sum of products over those terms and the slice's incoming carry. Slices are chained, so the carry leaving one slice is the carry entering the next. Each sum bit is the XOR of the two operand bits and the carry entering that bit.

The default width is 30 bits, which gives ten slices. Any width that is a multiple of three can be chosen. Any other width stops elaboration with an error.

Top module: `cla_group_adder`

## Requirements
- R1: `sum_out` equals the low `WIDTH` bits of the arithmetic value `op_a + op_b + carry_in`, with both operands read as unsigned.
- R2: `carry_out` equals bit `WIDTH` of that same arithmetic value.
- R3: When `op_b` is the bitwise complement of `op_a` and `carry_in` is 1, `sum_out` is all zeros and `carry_out` is 1. This covers all-ones plus zero plus carry, and the two alternating patterns 0101… plus 1010…. The carry crosses every slice in this case.
- R4: When both operands are zero, `carry_out` is 0 and `sum_out` equals `carry_in` in bit 0 with zeros above it.
- R5: The carry leaving slice k (bits 3k to 3k+2) equals bit 3 of the 4-bit value (op_a slice + op_b slice + carry entering slice k). The carry entering slice 0 is `carry_in`. Example: op_a = 2^(3k)−1, op_b = 1, carry_in = 0 gives sum_out = 2^(3k) and carry_out = 0.
- R6: When both operands are all ones, `carry_out` is 1 and `sum_out` is all ones with bit 0 equal to `carry_in`.
- R7: `WIDTH` is a parameter (default 30, ten slices). Any multiple of three gives a correct adder, and any other value is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| carry_in | input | 1 | Forced carry into bit 0 |
| sum_out | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry leaving the top bit |

## Verification
Two functions can act on the same sum bit at once: the lookahead inside a slice, and the carry that enters the slice from the one below. When that incoming carry has to pass through a slice whose internal propagate chain is also fully open, any mistake in combining the two terms shows up in the sum.

The bench provokes this case in two ways. It sweeps a 6-bit instance exhaustively over every operand pair and both carry values. On the 30-bit instance it drives complement pairs, alternating patterns and per-slice boundary operands, in addition to random operands.

Each result is judged against the integer sum `op_a + op_b + carry_in`, computed in the bench. Both the sum and the carry-out are compared.

// File: rtl/cla_grp_pkg.sv
// Package: shared constants and types for the grouped carry-lookahead adder.
// Assumes: every slice is exactly GROUP_BITS wide.
package cla_grp_pkg;

    // Number of bit positions resolved by one lookahead slice.
    localparam int unsigned GROUP_BITS = 3;

    // Per-bit generate and propagate pair.
    typedef struct packed {
        logic gen;
        logic prop;
    } pg_t;

    // Number of slices for a given width.
    function automatic int unsigned group_count(input int unsigned width);
        return width / GROUP_BITS;
    endfunction

endpackage

// File: rtl/cla_pg_cell.sv
// Module: one-bit generate/propagate former.
// Does: gen = a AND b, prop = a OR b (the inclusive-OR form of propagate).
// Assumes: nothing; purely combinational.
module cla_pg_cell
    import cla_grp_pkg::*;
(
    input  logic bit_a,
    input  logic bit_b,
    output pg_t  pg
);

    // Form the pair for this bit position.
    always_comb begin
        pg.gen  = bit_a & bit_b;
        pg.prop = bit_a | bit_b;
    end

endmodule

// File: rtl/cla_group_lookahead.sv
// Module: full carry lookahead across one slice.
// Does: produces the carry out of every bit in the slice as a flat
//       sum of products of generate/propagate terms and the slice carry-in.
// Assumes: GB is small (three by default), so the flat form stays shallow.
module cla_group_lookahead
    import cla_grp_pkg::*;
#(
    parameter int unsigned GB = GROUP_BITS
) (
    input  pg_t [GB-1:0] pg_vec,
    input  logic         grp_cin,
    output logic [GB-1:0] carry_vec
);

    // Carry out of bit idx: OR over j<=idx of gen[j]·prop[j+1..idx], plus prop[0..idx]·cin.
    function automatic logic la_carry(input pg_t [GB-1:0] pv,
                                      input logic cin,
                                      input int unsigned idx);
        logic acc;
        logic term;
        acc = cin;
        for (int unsigned k = 0; k < GB; k++) begin
            if (k <= idx) acc = acc & pv[k].prop;
        end
        for (int unsigned j = 0; j < GB; j++) begin
            if (j <= idx) begin
                term = pv[j].gen;
                for (int unsigned k = 0; k < GB; k++) begin
                    if (k > j && k <= idx) term = term & pv[k].prop;
                end
                acc = acc | term;
            end
        end
        return acc;
    endfunction

    // One flat product-sum per carry of the slice.
    for (genvar i = 0; i < GB; i++) begin : g_carry
        assign carry_vec[i] = la_carry(pg_vec, grp_cin, i);
    end

endmodule

// File: rtl/cla_sum_slice.sv
// Module: sum bits of one slice.
// Does: sum[i] = a[i] XOR b[i] XOR carry entering bit i.
// Assumes: cin_vec[i] is the carry into bit i, already resolved.
module cla_sum_slice #(
    parameter int unsigned GB = 3
) (
    input  logic [GB-1:0] slice_a,
    input  logic [GB-1:0] slice_b,
    input  logic [GB-1:0] cin_vec,
    output logic [GB-1:0] slice_sum
);

    // Three-input parity per bit.
    always_comb begin
        slice_sum = slice_a ^ slice_b ^ cin_vec;
    end

endmodule

// File: rtl/cla_group_adder.sv
// Module: top of the grouped carry-lookahead adder.
// Does: splits WIDTH bits into slices of GROUP_BITS with full lookahead inside
//       each slice and a ripple of slice carries from the least to the most significant.
// Assumes: WIDTH is a multiple of GROUP_BITS; otherwise elaboration fails.
module cla_group_adder
    import cla_grp_pkg::*;
#(
    parameter int unsigned WIDTH = 30
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);

    localparam int unsigned GB      = GROUP_BITS;
    localparam int unsigned NGROUPS = group_count(WIDTH);

    // Reject widths that do not split evenly into slices (R7).
    if ((WIDTH % GB) != 0 || WIDTH == 0) begin : g_bad_width
        $error("cla_group_adder: WIDTH must be a nonzero multiple of 3");
    end

    // Slice carries: entry k enters slice k, entry NGROUPS leaves the top.
    logic [NGROUPS:0] grp_carry;

    assign grp_carry[0] = carry_in;

    for (genvar g = 0; g < NGROUPS; g++) begin : g_slice
        pg_t  [GB-1:0] pg_vec;
        logic [GB-1:0] c_out_vec;
        logic [GB-1:0] c_in_vec;

        for (genvar b = 0; b < GB; b++) begin : g_bit
            cla_pg_cell u_pg (
                .bit_a (op_a[g*GB + b]),
                .bit_b (op_b[g*GB + b]),
                .pg    (pg_vec[b])
            );
        end

        cla_group_lookahead #(.GB(GB)) u_la (
            .pg_vec    (pg_vec),
            .grp_cin   (grp_carry[g]),
            .carry_vec (c_out_vec)
        );

        // Carry entering each bit: slice carry for bit 0, lookahead carries above.
        assign c_in_vec = {c_out_vec[GB-2:0], grp_carry[g]};

        cla_sum_slice #(.GB(GB)) u_sum (
            .slice_a   (op_a[g*GB +: GB]),
            .slice_b   (op_b[g*GB +: GB]),
            .cin_vec   (c_in_vec),
            .slice_sum (sum_out[g*GB +: GB])
        );

        assign grp_carry[g+1] = c_out_vec[GB-1];
    end

    assign carry_out = grp_carry[NGROUPS];

endmodule

// File: rtl/cla_adder_chk.sv
// Module: checker for cla_group_adder, attached by bind.
// Does: compares ports and slice carries against arithmetic references.
// Assumes: combinational settle; checks skip while any input is unknown.
module cla_adder_chk #(
    parameter int unsigned WIDTH = 30
) (
    input logic [WIDTH-1:0]   op_a,
    input logic [WIDTH-1:0]   op_b,
    input logic               carry_in,
    input logic [WIDTH-1:0]   sum_out,
    input logic               carry_out,
    input logic [WIDTH/3:0]   grp_carry
);

    localparam int unsigned NG = WIDTH / 3;

    logic [WIDTH:0] ref_total;
    logic           inputs_known;

    // Arithmetic reference for the whole word.
    always_comb begin
        ref_total    = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
        inputs_known = !$isunknown({op_a, op_b, carry_in});
    end

    // Whole-word and corner-case checks.
    always_comb begin
        if (inputs_known) begin
            AST_SUM_MATCH: assert (sum_out == ref_total[WIDTH-1:0]); // R1
            AST_CARRY_MATCH: assert (carry_out == ref_total[WIDTH]); // R2
            if (op_b == ~op_a && carry_in) begin
                AST_FULL_PROPAGATE: assert (sum_out == '0 && carry_out); // R3
            end
            if (op_a == '0 && op_b == '0) begin
                AST_ZERO_OPERANDS: assert (!carry_out && sum_out == {{(WIDTH-1){1'b0}}, carry_in}); // R4
            end
            if (op_a == '1 && op_b == '1) begin
                AST_DOUBLE_ONES: assert (carry_out && sum_out[WIDTH-1:1] == '1 && sum_out[0] == carry_in); // R6
            end
        end
    end

    // Per-slice carry against a 4-bit arithmetic sum of the slice.
    for (genvar g = 0; g < NG; g++) begin : g_chk
        logic [3:0] slice_total;
        always_comb begin
            slice_total = {1'b0, op_a[g*3 +: 3]} + {1'b0, op_b[g*3 +: 3]} + {3'b000, grp_carry[g]};
            if (inputs_known) begin
                AST_SLICE_CARRY: assert (grp_carry[g+1] == slice_total[3]); // R5
            end
        end
    end

    always_comb begin
        if (inputs_known) begin
            AST_SLICE0_ENTRY: assert (grp_carry[0] == carry_in); // R5
        end
    end

endmodule

bind cla_group_adder cla_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .grp_carry (grp_carry)
);

// File: tb/cla_group_adder_tb.sv
// Bench: exhaustive sweep of a 6-bit instance plus directed and random
// patterns on the default 30-bit instance; references computed arithmetically.
module cla_group_adder_tb_top;

    localparam int unsigned WB = 30;
    localparam int unsigned WS = 6;

    logic clk;
    logic rst_n;

    logic [WB-1:0] a_big, b_big, s_big;
    logic          ci_big, co_big;
    logic [WS-1:0] a_sm, b_sm, s_sm;
    logic          ci_sm, co_sm;

    int unsigned n_cmp;
    int unsigned n_bad;

    cla_group_adder #(.WIDTH(WB)) dut_i (
        .op_a (a_big), .op_b (b_big), .carry_in (ci_big),
        .sum_out (s_big), .carry_out (co_big)
    );

    cla_group_adder #(.WIDTH(WS)) dut_small_i (
        .op_a (a_sm), .op_b (b_sm), .carry_in (ci_sm),
        .sum_out (s_sm), .carry_out (co_sm)
    );

    // 50 MHz clock.
    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Watchdog: counts as a failed check and still prints the summary.
    initial begin
        #(64'd20 * 64'd200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Drive the 30-bit instance, wait away from the edge, compare both outputs.
    task automatic check_big(input logic [WB-1:0] a, input logic [WB-1:0] b,
                             input logic ci, input string req);
        logic [WB:0] exp_v;
        @(negedge clk);
        a_big = a; b_big = b; ci_big = ci;
        exp_v = {1'b0, a} + {1'b0, b} + {{WB{1'b0}}, ci};
        #2;
        n_cmp++;
        if ({co_big, s_big} !== exp_v) begin
            n_bad++;
            $display("FAIL %s: a=%h b=%h ci=%b actual=%h expected=%h",
                     req, a, b, ci, {co_big, s_big}, exp_v);
        end
    endtask

    // Same for the 6-bit instance.
    task automatic check_small(input logic [WS-1:0] a, input logic [WS-1:0] b,
                               input logic ci, input string req);
        logic [WS:0] exp_v;
        a_sm = a; b_sm = b; ci_sm = ci;
        exp_v = {1'b0, a} + {1'b0, b} + {{WS{1'b0}}, ci};
        #1;
        n_cmp++;
        if ({co_sm, s_sm} !== exp_v) begin
            n_bad++;
            $display("FAIL %s: a=%h b=%h ci=%b actual=%h expected=%h",
                     req, a, b, ci, {co_sm, s_sm}, exp_v);
        end
    endtask

    initial begin
        logic [WB-1:0] alt;
        n_cmp = 0; n_bad = 0;
        rst_n = 1'b0;
        a_big = '0; b_big = '0; ci_big = 1'b0;
        a_sm = '0;  b_sm = '0;  ci_sm = 1'b0;
        repeat (3) @(posedge clk);
        // Reset state: zero operands give zero outputs (R4).
        @(negedge clk);
        n_cmp++;
        if (s_big !== '0 || co_big !== 1'b0) begin
            n_bad++;
            $display("FAIL R4 reset: actual=%h expected=0", {co_big, s_big});
        end
        rst_n = 1'b1;

        // R4: zero operands with each carry.
        check_big('0, '0, 1'b0, "R4");
        check_big('0, '0, 1'b1, "R4");
        // R3: complement pairs with carry in, incl. all-ones and alternating.
        alt = '0;
        for (int i = 0; i < WB; i += 2) alt[i] = 1'b1;
        check_big('1, '0, 1'b1, "R3");
        check_big(alt, ~alt, 1'b1, "R3");
        check_big(~alt, alt, 1'b1, "R3");
        check_big(alt, ~alt, 1'b0, "R1");
        check_big(alt, alt, 1'b1, "R1");
        // R6: both operands all ones.
        check_big('1, '1, 1'b0, "R6");
        check_big('1, '1, 1'b1, "R6");
        // R5: carry crossing each slice boundary.
        for (int k = 1; k < WB / 3; k++) begin
            check_big((30'd1 << (3 * k)) - 30'd1, 30'd1, 1'b0, "R5");
            check_big((30'd1 << (3 * k)) - 30'd1, 30'd0, 1'b1, "R5");
        end
        // R2: top-bit carries.
        check_big(30'h2000_0000, 30'h2000_0000, 1'b0, "R2");
        check_big(30'h3FFF_FFFF, 30'd1, 1'b0, "R2");
        // R1/R2: random operands.
        for (int i = 0; i < 3000; i++) begin
            check_big(WB'($urandom), WB'($urandom), 1'($urandom), "R1");
        end

        // R7: exhaustive sweep of a 6-bit instance, both carries.
        @(negedge clk);
        for (int a = 0; a < (1 << WS); a++) begin
            for (int b = 0; b < (1 << WS); b++) begin
                check_small(WS'(a), WS'(b), 1'b0, "R7");
                check_small(WS'(a), WS'(b), 1'b1, "R7");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule